// File: doc/BRIEF.md
# Current-Sense ADC Register Front End

This block is the digital register side of a current-measurement converter. A byte-wide register bus with address, write data, write strobe, read strobe and read data reaches a set of configuration registers (operating mode, input channel, decimation, settle delay, averaging), an on/off control and a conversion trigger. It also provides three read-only identification bytes, a status byte and a 16-bit result. A reset-control byte can be changed only right after an unlock key has been written.

The analog converter is modelled by a timer. A conversion request on an enabled block starts the timer. Its length depends on the programmed settle delay and decimation code. When the timer expires, the block captures the `sample_in` bus as the result, marks the conversion complete and raises `eoc_irq` for one clock cycle. Software either waits for that pulse or polls the status byte, which reports a finished conversion only as the bit pair "complete set, pending clear".

Top module: `cadc_regfront`

## Requirements
- R1: Reads of address 0x04 return 8, address 0x05 returns 3, address 0x01 returns 1, and any address that is not decoded returns 0.
- R2: Configuration readback keeps only the implemented bits:
  - 0x40 keeps bits 7..3 (operating mode, 0 is normal) and bit 0 (trim enable).
  - 0x46 keeps bit 7 (block on).
  - 0x50 keeps bits 3..2 (decimation code, 0 selects ratio 512).
  - 0x51 keeps all 8 bits (settle cycles).
  - 0x5A keeps bits 2..0 (averaging count).
  - 0x5B keeps bit 7 (averaging on).
  - All other bits of these registers read 0.
- R3: The channel register at 0x48 accepts only the write values 0, 1, 3, 5 and 6. A write of any other value leaves the register unchanged.
- R4: A write to the reset-control byte at 0xDA changes it only if the bus write just before it was 0xA5 to address 0xD0. Otherwise the write is dropped. Bit 2 of this byte is the follow-warm-reset flag.
- R5: The unlock key is used up by the next bus write to any address. A key followed by some other write, or a key of the wrong value, does not unlock 0xDA.
- R6: While the block is on, a write with bit 7 set to 0x52 sets request-pending (status 0x08 bit 1) and clears end-of-conversion (status bit 0). Status therefore reads 0x02 during a conversion.
- R7: A conversion ends N = settle + 16·2^dec clock edges after the edge that accepted the request. At that edge `sample_in` is captured (low byte at 0x60, high byte at 0x61), status becomes 0x01, and `eoc_irq` is high for exactly one cycle.
- R8: A conversion request while the block is off is ignored: status, result and interrupt do not change.
- R9: Turning the block off during a conversion aborts it. Pending is cleared, no interrupt follows and the result keeps its old value.
- R10: A request while a conversion is pending is ignored and does not restart the timer.
- R11: After a synchronous reset, every register and the status byte read 0 and `eoc_irq` is low. Read data appears on the clock edge where the read strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| sample_in | input | 16 | Converter sample captured at conversion end |
| eoc_irq | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The bench targets the key guard at its edges: a protected write with no key, a key followed by an unrelated write, a wrong key value, and a second protected write after one good key. A guard that stays armed, or that counts reads as consumers, would let one of those writes through. It measures conversion length in edges for two settle/decimation settings and for a repeated request. An off-by-one timer, or one that restarts on a second request, shows up as a wrong count. It also issues requests while the block is off and turns the block off mid-conversion, so a design that ignores the on bit would either raise a stray pulse or overwrite the result.

// File: rtl/cadc_pkg.sv
`timescale 1ns/1ps
package cadc_pkg;
    localparam int AW    = 8;
    localparam int DW    = 8;
    localparam int RES_W = 16;

    localparam logic [AW-1:0] A_REV    = 8'h01;
    localparam logic [AW-1:0] A_TYPE   = 8'h04;
    localparam logic [AW-1:0] A_SUBT   = 8'h05;
    localparam logic [AW-1:0] A_STAT   = 8'h08;
    localparam logic [AW-1:0] A_MODE   = 8'h40;
    localparam logic [AW-1:0] A_EN     = 8'h46;
    localparam logic [AW-1:0] A_CHAN   = 8'h48;
    localparam logic [AW-1:0] A_DIG    = 8'h50;
    localparam logic [AW-1:0] A_SETTLE = 8'h51;
    localparam logic [AW-1:0] A_REQ    = 8'h52;
    localparam logic [AW-1:0] A_AVG    = 8'h5A;
    localparam logic [AW-1:0] A_AVGEN  = 8'h5B;
    localparam logic [AW-1:0] A_RES_LO = 8'h60;
    localparam logic [AW-1:0] A_RES_HI = 8'h61;
    localparam logic [AW-1:0] A_KEY    = 8'hD0;
    localparam logic [AW-1:0] A_RSTCTL = 8'hDA;

    localparam logic [DW-1:0] ID_TYPE = 8'd8;
    localparam logic [DW-1:0] ID_SUBT = 8'd3;
    localparam logic [DW-1:0] ID_REV  = 8'd1;
    localparam logic [DW-1:0] UNLOCK  = 8'hA5;

    typedef struct packed {
        logic          we;
        logic          re;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } bus_t;

    typedef struct packed {
        logic [4:0]    op_mode;
        logic          trim;
        logic          enable;
        logic [2:0]    chan;
        logic [1:0]    dec;
        logic [7:0]    settle;
        logic [2:0]    avg;
        logic          avg_en;
        logic [DW-1:0] rstctl;
    } cfg_t;

    function automatic logic chan_ok(input logic [DW-1:0] v);
        logic ok;
        case (v)
            8'd0, 8'd1, 8'd3, 8'd5, 8'd6: ok = 1'b1;
            default:                      ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic logic [15:0] conv_len(input logic [7:0] settle,
                                             input logic [1:0] dec,
                                             input logic [15:0] base);
        return {8'd0, settle} + (base << dec);
    endfunction
endpackage

// File: rtl/cadc_keyguard.sv
`timescale 1ns/1ps
module cadc_keyguard
    import cadc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  bus_t bus,
    output logic armed,
    output logic prot_wr
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (bus.we) begin
            armed_q <= (bus.addr == A_KEY) && (bus.wdata == UNLOCK);
        end
    end

    assign armed   = armed_q;
    assign prot_wr = bus.we && (bus.addr == A_RSTCTL) && armed_q;
endmodule

// File: rtl/cadc_cfg_regs.sv
`timescale 1ns/1ps
module cadc_cfg_regs
    import cadc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  bus_t bus,
    input  logic prot_wr,
    output cfg_t cfg
);
    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            if (bus.we) begin
                case (bus.addr)
                    A_MODE: begin
                        cfg_q.op_mode <= bus.wdata[7:3];
                        cfg_q.trim    <= bus.wdata[0];
                    end
                    A_EN:     cfg_q.enable <= bus.wdata[7];
                    A_CHAN:   if (chan_ok(bus.wdata)) cfg_q.chan <= bus.wdata[2:0];
                    A_DIG:    cfg_q.dec    <= bus.wdata[3:2];
                    A_SETTLE: cfg_q.settle <= bus.wdata;
                    A_AVG:    cfg_q.avg    <= bus.wdata[2:0];
                    A_AVGEN:  cfg_q.avg_en <= bus.wdata[7];
                    default: ;
                endcase
            end
            if (prot_wr) begin
                cfg_q.rstctl <= bus.wdata;
            end
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/cadc_conv_timer.sv
`timescale 1ns/1ps
module cadc_conv_timer
    import cadc_pkg::*;
#(
    parameter int BASE_CYC = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             start,
    input  logic [7:0]       settle,
    input  logic [1:0]       dec,
    input  logic [RES_W-1:0] sample,
    output logic             pend,
    output logic             eoc,
    output logic [RES_W-1:0] result,
    output logic             irq
);
    localparam logic [15:0] BASE16 = 16'(BASE_CYC);

    logic [15:0] cnt_q;
    logic [15:0] len;

    assign len = conv_len(settle, dec, BASE16);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend   <= 1'b0;
            eoc    <= 1'b0;
            result <= '0;
            irq    <= 1'b0;
            cnt_q  <= '0;
        end else begin
            irq <= 1'b0;
            if (!enable) begin
                pend <= 1'b0;
            end else if (start && !pend) begin
                pend  <= 1'b1;
                eoc   <= 1'b0;
                cnt_q <= len - 16'd1;
            end else if (pend) begin
                if (cnt_q == 16'd0) begin
                    pend   <= 1'b0;
                    eoc    <= 1'b1;
                    result <= sample;
                    irq    <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 16'd1;
                end
            end
        end
    end
endmodule

// File: rtl/cadc_regfront.sv
`timescale 1ns/1ps
module cadc_regfront
    import cadc_pkg::*;
#(
    parameter int BASE_CYC = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    input  logic             bus_we,
    input  logic             bus_re,
    output logic [DW-1:0]    bus_rdata,
    input  logic [RES_W-1:0] sample_in,
    output logic             eoc_irq
);
    bus_t             bus;
    cfg_t             cfg;
    logic             key_armed;
    logic             prot_wr;
    logic             req_start;
    logic             conv_pend;
    logic             conv_eoc;
    logic [RES_W-1:0] conv_res;
    logic [DW-1:0]    rd_mux;
    logic [DW-1:0]    rdata_q;

    assign bus = '{we: bus_we, re: bus_re, addr: bus_addr, wdata: bus_wdata};
    assign req_start = bus.we && (bus.addr == A_REQ) && bus.wdata[7];

    cadc_keyguard u_key (
        .clk    (clk),
        .rst    (rst),
        .bus    (bus),
        .armed  (key_armed),
        .prot_wr(prot_wr)
    );

    cadc_cfg_regs u_cfg (
        .clk    (clk),
        .rst    (rst),
        .bus    (bus),
        .prot_wr(prot_wr),
        .cfg    (cfg)
    );

    cadc_conv_timer #(.BASE_CYC(BASE_CYC)) u_conv (
        .clk   (clk),
        .rst   (rst),
        .enable(cfg.enable),
        .start (req_start),
        .settle(cfg.settle),
        .dec   (cfg.dec),
        .sample(sample_in),
        .pend  (conv_pend),
        .eoc   (conv_eoc),
        .result(conv_res),
        .irq   (eoc_irq)
    );

    always_comb begin
        case (bus.addr)
            A_REV:    rd_mux = ID_REV;
            A_TYPE:   rd_mux = ID_TYPE;
            A_SUBT:   rd_mux = ID_SUBT;
            A_STAT:   rd_mux = {6'd0, conv_pend, conv_eoc};
            A_MODE:   rd_mux = {cfg.op_mode, 2'b00, cfg.trim};
            A_EN:     rd_mux = {cfg.enable, 7'd0};
            A_CHAN:   rd_mux = {5'd0, cfg.chan};
            A_DIG:    rd_mux = {4'd0, cfg.dec, 2'b00};
            A_SETTLE: rd_mux = cfg.settle;
            A_REQ:    rd_mux = {conv_pend, 7'd0};
            A_AVG:    rd_mux = {5'd0, cfg.avg};
            A_AVGEN:  rd_mux = {cfg.avg_en, 7'd0};
            A_RES_LO: rd_mux = conv_res[7:0];
            A_RES_HI: rd_mux = conv_res[15:8];
            A_RSTCTL: rd_mux = cfg.rstctl;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (bus.re) begin
            rdata_q <= rd_mux;
        end
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/cadc_regfront_chk.sv
`timescale 1ns/1ps
module cadc_regfront_chk (
    input logic       clk,
    input logic       rst,
    input logic       irq,
    input logic       eoc,
    input logic       pend,
    input logic       enable,
    input logic       we,
    input logic [7:0] addr,
    input logic       armed,
    input logic [7:0] rstctl
);
    AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R7
    AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (eoc && !pend)); // R7
    AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(eoc && pend)); // R6
    AST_LOCKED_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (we && addr == 8'hDA && !armed) |=> $stable(rstctl)); // R4
    AST_OFF_NO_PEND: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !pend); // R9
    AST_OFF_REQ_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
        (!enable && !pend) |=> !irq); // R8
endmodule

bind cadc_regfront cadc_regfront_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .irq   (eoc_irq),
    .eoc   (conv_eoc),
    .pend  (conv_pend),
    .enable(cfg.enable),
    .we    (bus_we),
    .addr  (bus_addr),
    .armed (key_armed),
    .rstctl(cfg.rstctl)
);

// File: tb/cadc_regfront_test.sv
`timescale 1ns/1ps
module cadc_regfront_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [7:0]  bus_rdata;
    logic [15:0] sample_in = '0;
    logic        eoc_irq;

    int checks = 0;
    int errors = 0;

    cadc_regfront uut (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_we   (bus_we),
        .bus_re   (bus_re),
        .bus_rdata(bus_rdata),
        .sample_in(sample_in),
        .eoc_irq  (eoc_irq)
    );

    always #10 clk = ~clk;

    // {address, write value, expected readback}
    localparam logic [23:0] VEC [8] = '{
        {8'h40, 8'hFF, 8'hF9},
        {8'h46, 8'h7F, 8'h00},
        {8'h48, 8'h06, 8'h06},
        {8'h50, 8'hFF, 8'h0C},
        {8'h51, 8'h33, 8'h33},
        {8'h5A, 8'hFF, 8'h07},
        {8'h5B, 8'hFF, 8'h80},
        {8'h46, 8'h80, 8'h80}
    };

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    // Counts negedges until eoc_irq is seen; returns 0 if none within lim.
    task automatic wait_irq(input int lim, output int n);
        n = 0;
        for (int k = 1; k <= lim; k++) begin
            @(negedge clk);
            if (eoc_irq) begin
                n = k;
                break;
            end
        end
    endtask

    task automatic count_irqs(input int cyc, output int n);
        n = 0;
        for (int k = 0; k < cyc; k++) begin
            @(negedge clk);
            if (eoc_irq) n++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        chk("R11", "irq after reset", 16'(eoc_irq), 16'h0);
        chk("R11", "rdata after reset", 16'(bus_rdata), 16'h0);
        rd(8'h08, d); chk("R11", "status", 16'(d), 16'h00);
        rd(8'h46, d); chk("R11", "enable", 16'(d), 16'h00);
        rd(8'hDA, d); chk("R11", "reset ctl", 16'(d), 16'h00);
        rd(8'h60, d); chk("R11", "result lo", 16'(d), 16'h00);

        // R1 identification
        rd(8'h04, d); chk("R1", "type id", 16'(d), 16'd8);
        rd(8'h05, d); chk("R1", "subtype id", 16'(d), 16'd3);
        rd(8'h01, d); chk("R1", "revision", 16'(d), 16'd1);
        rd(8'h77, d); chk("R1", "undecoded", 16'(d), 16'd0);

        // R2 vector table
        foreach (VEC[i]) begin
            wr(VEC[i][23:16], VEC[i][15:8]);
            rd(VEC[i][23:16], d);
            chk("R2", $sformatf("readback %h", VEC[i][23:16]), 16'(d), 16'(VEC[i][7:0]));
        end

        // R3 channel codes
        wr(8'h48, 8'h03); rd(8'h48, d); chk("R3", "chan 3", 16'(d), 16'h03);
        wr(8'h48, 8'h02); rd(8'h48, d); chk("R3", "chan 2 ignored", 16'(d), 16'h03);
        wr(8'h48, 8'h0D); rd(8'h48, d); chk("R3", "chan 0x0D ignored", 16'(d), 16'h03);
        wr(8'h48, 8'h05); rd(8'h48, d); chk("R3", "chan 5", 16'(d), 16'h05);

        // R4 / R5 protected register
        wr(8'hDA, 8'h04); rd(8'hDA, d); chk("R4", "no key", 16'(d), 16'h00);
        wr(8'hD0, 8'hA5); wr(8'hDA, 8'h04); rd(8'hDA, d);
        chk("R4", "keyed warm-follow bit", 16'(d), 16'h04);
        wr(8'hD0, 8'hA5); wr(8'h40, 8'h00); wr(8'hDA, 8'hFF); rd(8'hDA, d);
        chk("R5", "key consumed by other write", 16'(d), 16'h04);
        wr(8'hD0, 8'h5A); wr(8'hDA, 8'hFF); rd(8'hDA, d);
        chk("R5", "wrong key", 16'(d), 16'h04);
        wr(8'hD0, 8'hA5); wr(8'hDA, 8'h00); wr(8'hDA, 8'hFF); rd(8'hDA, d);
        chk("R5", "one write per key", 16'(d), 16'h00);

        // R7 conversion with settle 0, decimation 0: 16 edges
        wr(8'h51, 8'h00); wr(8'h50, 8'h00);
        sample_in = 16'hBEEF;
        wr(8'h52, 8'h80);
        wait_irq(1000, n);
        chk("R7", "length 16", 16'(n), 16'd16);
        @(negedge clk);
        chk("R7", "irq one cycle", 16'(eoc_irq), 16'h0);
        rd(8'h08, d); chk("R7", "status done", 16'(d), 16'h01);
        rd(8'h60, d); chk("R7", "result lo", 16'(d), 16'hEF);
        rd(8'h61, d); chk("R7", "result hi", 16'(d), 16'hBE);

        // R6 status while pending
        wr(8'h52, 8'h80);
        rd(8'h08, d); chk("R6", "status pending", 16'(d), 16'h02);
        wait_irq(1000, n);

        // R7 settle 4, decimation 1: 4 + 32 = 36 edges
        wr(8'h51, 8'h04); wr(8'h50, 8'h04);
        sample_in = 16'hA55A;
        wr(8'h52, 8'h80);
        wait_irq(1000, n);
        chk("R7", "length 36", 16'(n), 16'd36);
        rd(8'h61, d); chk("R7", "result hi 2", 16'(d), 16'hA5);

        // R10 second request does not restart
        wr(8'h51, 8'h00); wr(8'h50, 8'h00);
        wr(8'h52, 8'h80);
        wr(8'h52, 8'h80);
        wait_irq(1000, n);
        chk("R10", "no restart", 16'(n), 16'd14);

        // R8 request while off
        wr(8'h46, 8'h00);
        sample_in = 16'h1234;
        wr(8'h52, 8'h80);
        count_irqs(40, n);
        chk("R8", "no irq while off", 16'(n), 16'd0);
        rd(8'h08, d); chk("R8", "status unchanged", 16'(d), 16'h01);
        rd(8'h60, d); chk("R8", "result unchanged", 16'(d), 16'h5A);

        // R9 abort by turning off mid-conversion
        wr(8'h46, 8'h80);
        wr(8'h52, 8'h80);
        wr(8'h46, 8'h00);
        count_irqs(40, n);
        chk("R9", "no irq after abort", 16'(n), 16'd0);
        rd(8'h08, d); chk("R9", "status idle", 16'(d), 16'h00);
        rd(8'h61, d); chk("R9", "result kept", 16'(d), 16'hA5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule